// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave

This block is the slave end of a two-wire serial memory with 2048 bytes. It watches the open-drain clock and data lines, which reach it as plain inputs. It drives the data line only through an output-enable, because the driven value is always low. Both lines pass through a synchroniser into the system clock domain before edges are taken.

After a START, the block takes in a select byte. That byte holds a fixed four-bit type code, the three upper memory address bits and a read/write flag. For a write, the next byte sets the eight low address bits and every byte after it is stored. For a read, bytes are streamed out for as long as the master acknowledges them. A single 11-bit address counter serves both directions and steps after every data byte.

A random read works in three steps. A write select and address byte are sent first. Then comes a repeated START and a read select byte. The STOP condition ends every transfer.

Top module: `i2c_mem_slave`

## Requirements
- R1: A START (data falling while clock is high) begins reception of a select byte from any state. A STOP (data rising while clock is high) returns the block to idle with the data line released, and the address counter keeps its value.
- R2: Until the first START, the block never drives the data line, whatever the lines do.
- R3: The select byte arrives MSB first. When bits [7:4] equal 4'b1010, the block pulls data low for the whole ninth clock. Bits [3:1] load address counter bits [10:8]. Bit 0 selects read (1) or write (0).
- R4: A select byte whose bits [7:4] differ from 4'b1010 gets no acknowledge. All following clocks are ignored until the next START, and no memory byte changes.
- R5: In a write, the first byte after the select byte loads address counter bits [7:0] and is acknowledged.
- R6: In a write, each later byte is stored at the address counter and acknowledged, and the counter then increments. It wraps from 0x7FF to 0x000.
- R7: A read starts at the counter as updated by the read select byte. The block sends 8 bits MSB first and releases the data line for the ninth clock.
- R8: When the master acknowledges a read byte, the next byte comes from the incremented address, wrapping from 0x7FF to 0x000.
- R9: When the master does not acknowledge a read byte, the block drives nothing more until a STOP or START.
- R10: The data output-enable changes only while the synchronised clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | High to pull the data line low |
| sda_o | output | 1 | Driven data value, constant 0 (open drain) |

## Verification
The bench uses the default parameters: type code 4'b1010, a two-stage synchroniser and the full 11-bit address space. With the full address space, the last location 0x7FF and the wrap to 0x000 can be reached in both a sequential write and a sequential read. With the default type code, a mismatched select byte can be sent next to matching ones. Serial clock phases last ten system clocks, which leaves room for the synchroniser and edge-detect latency before each sample.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int unsigned HI_W   = 3;
  localparam int unsigned LO_W   = 8;
  localparam int unsigned AW     = HI_W + LO_W;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_HOLD
  } bus_state_e;

  typedef enum logic [1:0] {
    RX_SEL,
    RX_ADDR,
    RX_DATA
  } rx_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= line_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  assign level_o = chain_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= level_o;
  end

  assign rise_o = level_o & ~prev_q;
  assign fall_o = ~level_o & prev_q;
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_mem_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [AW-1:0]     addr_o,
  output logic              we_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o
);
  bus_state_e        state_q;
  rx_kind_e          kind_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] txsh_q;
  logic [AW-1:0]     addr_q;
  logic              rd_q;
  logic              mack_q;
  logic              oe_q;

  logic start_det, stop_det, byte_end;

  // clock high on both sides of the data edge
  assign start_det = scl_lvl_i & ~scl_rise_i & sda_fall_i;
  assign stop_det  = scl_lvl_i & ~scl_rise_i & sda_rise_i;
  assign byte_end  = scl_fall_i && (bit_cnt_q == CNT_W'(BYTE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= RX_SEL;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      txsh_q    <= '0;
      addr_q    <= '0;
      rd_q      <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_RX;
      kind_q    <= RX_SEL;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise_i) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (byte_end) begin
            unique case (kind_q)
              RX_SEL: begin
                if (shreg_q[7:4] == TYPE_CODE) begin
                  addr_q[AW-1:LO_W] <= shreg_q[HI_W:1];
                  rd_q              <= shreg_q[0];
                  oe_q              <= 1'b1;
                  state_q           <= ST_ACK;
                end else begin
                  state_q <= ST_HOLD;
                end
              end
              RX_ADDR: begin
                addr_q[LO_W-1:0] <= shreg_q;
                oe_q             <= 1'b1;
                state_q          <= ST_ACK;
              end
              default: begin
                addr_q  <= addr_q + 1'b1;
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            bit_cnt_q <= '0;
            if (rd_q) begin
              txsh_q  <= rd_data_i;
              oe_q    <= ~rd_data_i[BYTE_W-1];
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
              kind_q  <= (kind_q == RX_SEL) ? RX_ADDR : RX_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (byte_end) begin
            oe_q    <= 1'b0;
            addr_q  <= addr_q + 1'b1;
            state_q <= ST_MACK;
          end else if (scl_fall_i && bit_cnt_q != '0) begin
            txsh_q <= {txsh_q[BYTE_W-2:0], 1'b0};
            oe_q   <= ~txsh_q[BYTE_W-2];
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_lvl_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              bit_cnt_q <= '0;
              txsh_q    <= rd_data_i;
              oe_q      <= ~rd_data_i[BYTE_W-1];
              state_q   <= ST_TX;
            end else begin
              state_q <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign we_o      = (state_q == ST_RX) && (kind_q == RX_DATA) && byte_end;
  assign wr_data_o = shreg_q;
  assign addr_o    = addr_q;
  assign sda_oe_o  = oe_q;

  p_start_rx_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det && !stop_det |=> state_q == ST_RX && kind_q == RX_SEL && bit_cnt_q == '0);

  p_stop_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> state_q == ST_IDLE && !sda_oe_o);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !sda_oe_o);

  p_ack_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ACK && $past(state_q) == ST_RX && $past(kind_q) == RX_SEL
    |-> $past(shreg_q[7:4]) == TYPE_CODE);

  p_mismatch_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RX && kind_q == RX_SEL && byte_end && shreg_q[7:4] != TYPE_CODE
    |=> state_q == ST_HOLD && !sda_oe_o);

  p_addr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_TX && byte_end |=> addr_q == AW'($past(addr_q) + 1'b1));

  p_nack_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_MACK && scl_fall_i && !mack_q |=> state_q == ST_HOLD && !sda_oe_o);

  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o != $past(sda_oe_o) |-> !$past(scl_lvl_i));

  p_bit_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= CNT_W'(BYTE_W));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [3:0]  TYPE_CODE   = 4'b1010,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic sda_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic [AW-1:0]     addr;
  logic              we;
  logic [BYTE_W-1:0] wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (scl_i),
    .level_o(scl_lvl),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (sda_i),
    .level_o(sda_lvl),
    .rise_o (sda_rise),
    .fall_o (sda_fall)
  );

  i2c_slave_fsm #(.TYPE_CODE(TYPE_CODE)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_lvl_i (scl_lvl),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_lvl_i (sda_lvl),
    .sda_rise_i(sda_rise),
    .sda_fall_i(sda_fall),
    .rd_data_i (rd_data),
    .addr_o    (addr),
    .we_o      (we),
    .wr_data_o (wr_data),
    .sda_oe_o  (sda_oe_o)
  );

  i2c_mem_array #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(addr),
    .wdata_i(wr_data),
    .raddr_i(addr),
    .rdata_o(rd_data)
  );

  assign sda_o = 1'b0;
endmodule

// File: tb/i2c_mem_slave_test.sv
`timescale 1ns/1ps
module i2c_mem_slave_test;
  localparam int Q = 10;
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {11'h000, 8'h3C}, {11'h7FF, 8'hE1}, {11'h3A5, 8'h5A},
    {11'h050, 8'hA5}, {11'h5C5, 8'hC3}, {11'h010, 8'h33}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, sda_out, sda_bus;
  int   errors = 0;
  int   checks = 0;
  int   viol = 0;
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_mem_slave uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .sda_oe_o(sda_oe),
    .sda_o   (sda_out)
  );

  // R10 monitor: output-enable may move only while the clock line is low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl_m) viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q/2);
    ack = ~sda_bus;
    wq(Q/2); scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(Q); scl_m = 1'b1; wq(Q/2);
      b = {b[6:0], sda_bus};
      wq(Q/2); scl_m = 1'b0;
    end
    wq(Q/2); sda_m = ~mack; wq(Q/2);
    scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [10:0] a, output logic ok);
    logic k1, k2;
    bstart();
    send({4'b1010, a[10:8], 1'b0}, k1);
    send(a[7:0], k2);
    ok = k1 & k2;
  endtask

  task automatic write1(input logic [10:0] a, input logic [7:0] d, output logic ok);
    logic k1, k2;
    set_addr(a, k1);
    send(d, k2);
    bstop();
    ok = k1 & k2;
  endtask

  task automatic read1(input logic [10:0] a, output logic [7:0] d);
    logic k1, k2;
    set_addr(a, k1);
    bstart();
    send({4'b1010, a[10:8], 1'b1}, k2);
    recv(1'b0, d);
    bstop();
  endtask

  initial begin
    logic ok, k;
    logic [7:0] d;
    wq(5);
    chk("R2 reset oe", {31'd0, sda_oe}, 32'd0);
    chk("R2 sda_o constant", {31'd0, sda_out}, 32'd0);
    rst_n = 1'b1;
    wq(5);

    // R2: a full select byte before any START draws no acknowledge
    send(8'hA0, k);
    chk("R2 no ack before START", {31'd0, k}, 32'd0);
    bstop();

    // table walk: R3 R5 R6 ack on write, R7 random read back
    for (int i = 0; i < NV; i++) begin
      write1(VEC[i][18:8], VEC[i][7:0], ok);
      chk("R5 write acks", {31'd0, ok}, 32'd1);
      read1(VEC[i][18:8], d);
      chk("R7 read back", {24'd0, d}, {24'd0, VEC[i][7:0]});
    end

    // R3: read select bits override upper address bits
    set_addr(11'h2C5, ok);
    bstart();
    send(8'b1010_101_1, k);
    chk("R3 read select ack", {31'd0, k}, 32'd1);
    recv(1'b0, d);
    bstop();
    chk("R3 upper bits from read select", {24'd0, d}, 32'hC3);

    // R1: STOP after address byte, counter kept, plain read picks it up
    set_addr(11'h050, ok);
    bstop();
    chk("R1 released after STOP", {31'd0, sda_oe}, 32'd0);
    bstart();
    send(8'b1010_000_1, k);
    recv(1'b0, d);
    bstop();
    chk("R1 read after STOP keeps counter", {24'd0, d}, 32'hA5);

    // R6: sequential write
    set_addr(11'h1FE, ok);
    for (int i = 0; i < 4; i++) begin
      send(8'h11 * (i + 1), k);
      chk("R6 data ack", {31'd0, k}, 32'd1);
    end
    bstop();
    // R8: sequential read
    set_addr(11'h1FE, ok);
    bstart();
    send(8'b1010_001_1, k);
    for (int i = 0; i < 4; i++) begin
      recv(i != 3, d);
      chk("R8 sequential read", {24'd0, d}, 32'h11 * (i + 1));
    end
    bstop();

    // R6/R8 wrap from 0x7FF to 0x000
    set_addr(11'h7FE, ok);
    send(8'hD0, k); send(8'hD1, k); send(8'hD2, k);
    bstop();
    read1(11'h000, d);
    chk("R6 write wraps to 0x000", {24'd0, d}, 32'hD2);
    set_addr(11'h7FE, ok);
    bstart();
    send(8'b1010_111_1, k);
    recv(1'b1, d); chk("R8 read 0x7FE", {24'd0, d}, 32'hD0);
    recv(1'b1, d); chk("R8 read 0x7FF", {24'd0, d}, 32'hD1);
    recv(1'b0, d); chk("R8 read wraps 0x000", {24'd0, d}, 32'hD2);
    bstop();

    // R4: wrong type code, no ack, following bytes ignored
    bstart();
    send(8'b1001_000_0, k);
    chk("R4 no ack on mismatch", {31'd0, k}, 32'd0);
    send(8'h10, k);
    chk("R4 addr byte ignored", {31'd0, k}, 32'd0);
    send(8'h77, k);
    chk("R4 data byte ignored", {31'd0, k}, 32'd0);
    bstop();
    read1(11'h010, d);
    chk("R4 memory unchanged", {24'd0, d}, 32'h33);

    // R9: after NACK nothing is driven until STOP
    set_addr(11'h3A5, ok);
    bstart();
    send(8'b1010_011_1, k);
    recv(1'b0, d);
    chk("R9 first byte", {24'd0, d}, 32'h5A);
    recv(1'b0, d);
    chk("R9 bus released after NACK", {24'd0, d}, 32'hFF);
    bstop();

    chk("R10 oe changes only with clock low", viol, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule